// File: doc/BRIEF.md
# Masked Commit-Trace Event Matcher

This block observes a stream of retired-instruction records, one per committed instruction. Each record has five fields: the instruction word, the PC it retired from, the PC control went to next, the memory address touched and the memory data moved. Each of several matchers holds a value and a care mask for every field. A matcher hits when all five fields agree with its value on every bit that its mask marks as cared. Each hit advances that matcher's counter. When the counter reaches the matcher's programmed threshold, the matcher emits a packet and its counter starts again from zero. A packet holds the matcher number and the address and data of the record that reached the threshold. Packets wait in a small FIFO until a downstream action engine takes them.

The trace input is a valid/ready stream. A record is consumed only on a cycle where `trace_valid` and `trace_ready` are both high. When a record fires one or more matchers, the block holds those packets in a pending register. It drops `trace_ready` until every pending packet has entered the FIFO. If the FIFO is full, `trace_ready` stays low and the producer must keep its record presented. No event is ever lost. The packet output is also valid/ready: a packet stays on the port unchanged until it is taken.

Software sets up the matchers through a plain command port. The port carries a matcher number, a register index and a data word, plus a clear strobe. The clear strobe wipes a single matcher back to its idle state.

Top module: `trace_matcher`

## Requirements
- R1: Per field, a mask bit of 1 makes that bit don't-care and a 0 makes it compared. An all-ones mask wildcards the whole field.
- R2: A matcher hits only when all five fields match. A single cared bit that differs in any field means no hit and leaves the counter unchanged.
- R3: Each hit adds one to the matcher's counter. The hit that brings the count to the threshold emits exactly one packet and returns the counter to zero.
- R4: A packet carries the firing matcher's number in `pkt_id` and the firing record's memory address and memory data in `pkt_addr` and `pkt_data`. With an empty queue, it appears on the output two cycles after the record's handshake.
- R5: A threshold of 0 disables a matcher: it never counts and never emits.
- R6: A command with `cfg_clear` high sets the selected matcher's values, masks, counter and threshold to zero. Other matchers are not affected.
- R7: The packet output follows valid/ready. While `pkt_valid` is high and `pkt_ready` is low, the packet stays stable. Packets leave in the order they were queued.
- R8: The queue holds 8 packets. If a pending packet finds the queue full, `trace_ready` stays low until the packet can enter. No packet is dropped.
- R9: A record is counted once for each valid/ready handshake, even when `trace_valid` is held high for many cycles while `trace_ready` is low.
- R10: If one record fires several matchers, their packets are queued one per cycle in ascending matcher number. `trace_ready` is low from the cycle after such a record until the last of those packets is queued.
- R11: After reset, `trace_ready` is 1, `pkt_valid` is 0 and all matchers are cleared as in R6.
- R12: `cfg_idx` selects the register. Index 0 to 4 are the values for instruction, source PC, destination PC, address and data, in that order. Index 8 to 12 are the masks for the same fields in the same order. Index 15 is the threshold, taken from the low bits of `cfg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Command strobe |
| cfg_clear | input | 1 | With cfg_valid: clear the selected matcher instead of writing |
| cfg_id | input | ID_W | Matcher number |
| cfg_idx | input | 4 | Register index (R12) |
| cfg_wdata | input | W | Write data |
| trace_valid | input | 1 | Trace record present |
| trace_ready | output | 1 | Trace record accepted this cycle when high; low means stall |
| tr_insn | input | W | Instruction word |
| tr_src_pc | input | W | PC of the retired instruction |
| tr_dst_pc | input | W | Next PC |
| tr_addr | input | W | Memory address |
| tr_data | input | W | Memory data |
| pkt_valid | output | 1 | Packet available |
| pkt_ready | input | 1 | Consumer takes the packet |
| pkt_id | output | ID_W | Firing matcher number |
| pkt_addr | output | W | Memory address of the firing record |
| pkt_data | output | W | Memory data of the firing record |

## Verification
The bench first fills the queue with the consumer stalled. It then checks that the next firing record lowers `trace_ready`. A design that overwrote its pending packet or pushed into a full FIFO would lose or corrupt one of the expected ten packets. One record is held at the input across a long stall: a design that counted every valid cycle would send extra packets, and the scoreboard rejects those. The bench also fires two matchers from one record and expects them in ascending matcher order. It checks partial masks, a single differing cared bit, a threshold of 3 with a record that misses in between, and a clear of one matcher. A design that did not restart its counter, or did not compare masked bits correctly, would emit packets at the wrong positions.

// File: rtl/trace_match_pkg.sv
package trace_match_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int IDX_W      = 4;

  typedef enum logic [2:0] {
    FLD_INSN   = 3'd0,
    FLD_SRC_PC = 3'd1,
    FLD_DST_PC = 3'd2,
    FLD_ADDR   = 3'd3,
    FLD_DATA   = 3'd4
  } field_e;

  localparam logic [IDX_W-1:0] IDX_THRESH = 4'hF;
  localparam int               IDX_MASK_BIT = 3;
endpackage

// File: rtl/tm_match_unit.sv
module tm_match_unit
  import trace_match_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_valid,
  input  logic                          cfg_clear,
  input  logic                          cfg_sel,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic [W-1:0]                  cfg_wdata,
  input  logic                          rec_take,
  input  logic [NUM_FIELDS-1:0][W-1:0]  rec,
  output logic                          fire
);
  logic [NUM_FIELDS-1:0][W-1:0] val_q, msk_q;
  logic [CNT_W-1:0]             cnt_q, thr_q;
  logic [NUM_FIELDS-1:0]        fld_ok;
  logic                         hit;
  logic [CNT_W:0]               cnt_inc;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
    assign fld_ok[f] = ((rec[f] ^ val_q[f]) & ~msk_q[f]) == '0;
  end

  assign hit     = rec_take && (&fld_ok) && (thr_q != '0);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign fire    = hit && (cnt_inc == {1'b0, thr_q});

  logic do_clear, do_write;
  assign do_clear = cfg_valid && cfg_sel && cfg_clear;
  assign do_write = cfg_valid && cfg_sel && !cfg_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      msk_q <= '0;
      thr_q <= '0;
    end else if (do_clear) begin
      val_q <= '0;
      msk_q <= '0;
      thr_q <= '0;
    end else if (do_write) begin
      if (cfg_idx == IDX_THRESH) begin
        thr_q <= cfg_wdata[CNT_W-1:0];
      end else begin
        for (int f = 0; f < NUM_FIELDS; f++) begin
          if (cfg_idx[2:0] == f[2:0]) begin
            if (cfg_idx[IDX_MASK_BIT]) msk_q[f] <= cfg_wdata;
            else                       val_q[f] <= cfg_wdata;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (do_clear)  cnt_q <= '0;
    else if (fire)      cnt_q <= '0;
    else if (hit)       cnt_q <= cnt_inc[CNT_W-1:0];
  end

  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == '0));
  a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == '0) |-> !fire);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    do_clear |=> (cnt_q == '0 && thr_q == '0 && msk_q == '0));
endmodule

// File: rtl/tm_pkt_fifo.sv
module tm_pkt_fifo #(
  parameter int DW    = 72,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  output logic          full,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          pop, do_push;

  assign full      = (cnt_q == CW'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign dout      = mem[rd_q];
  assign pop       = out_valid && out_ready;
  assign do_push   = push && !full;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (pop)     rd_q <= bump(rd_q);
      case ({do_push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout)));
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/trace_matcher.sv
module trace_matcher
  import trace_match_pkg::*;
#(
  parameter int W         = 32,
  parameter int NUM_MATCH = 2,
  parameter int CNT_W     = 16,
  parameter int Q_DEPTH   = 8,
  localparam int ID_W     = (NUM_MATCH > 1) ? $clog2(NUM_MATCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic             cfg_clear,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic [3:0]       cfg_idx,
  input  logic [W-1:0]     cfg_wdata,
  input  logic             trace_valid,
  output logic             trace_ready,
  input  logic [W-1:0]     tr_insn,
  input  logic [W-1:0]     tr_src_pc,
  input  logic [W-1:0]     tr_dst_pc,
  input  logic [W-1:0]     tr_addr,
  input  logic [W-1:0]     tr_data,
  output logic             pkt_valid,
  input  logic             pkt_ready,
  output logic [ID_W-1:0]  pkt_id,
  output logic [W-1:0]     pkt_addr,
  output logic [W-1:0]     pkt_data
);
  localparam int PKT_W = ID_W + 2 * W;

  logic [NUM_FIELDS-1:0][W-1:0] rec;
  logic [NUM_MATCH-1:0]         fire, pend_q, sel_oh;
  logic [ID_W-1:0]              sel_id;
  logic [W-1:0]                 paddr_q, pdata_q;
  logic                         take, push, q_full;
  logic [PKT_W-1:0]             q_in, q_out;

  assign rec[FLD_INSN]   = tr_insn;
  assign rec[FLD_SRC_PC] = tr_src_pc;
  assign rec[FLD_DST_PC] = tr_dst_pc;
  assign rec[FLD_ADDR]   = tr_addr;
  assign rec[FLD_DATA]   = tr_data;

  assign trace_ready = (pend_q == '0);
  assign take        = trace_valid && trace_ready;

  for (genvar m = 0; m < NUM_MATCH; m++) begin : g_mu
    tm_match_unit #(.W(W), .CNT_W(CNT_W)) u_mu (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_valid (cfg_valid),
      .cfg_clear (cfg_clear),
      .cfg_sel   (cfg_id == ID_W'(m)),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .rec_take  (take),
      .rec       (rec),
      .fire      (fire[m])
    );
  end

  always_comb begin
    sel_oh = '0;
    sel_id = '0;
    for (int m = NUM_MATCH - 1; m >= 0; m--) begin
      if (pend_q[m]) begin
        sel_oh = '0;
        sel_oh[m] = 1'b1;
        sel_id = ID_W'(m);
      end
    end
  end

  assign push = (pend_q != '0) && !q_full;
  assign q_in = {sel_id, paddr_q, pdata_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else if (take && (fire != '0)) begin
      pend_q  <= fire;
      paddr_q <= tr_addr;
      pdata_q <= tr_data;
    end else if (push) begin
      pend_q  <= pend_q & ~sel_oh;
    end
  end

  tm_pkt_fifo #(.DW(PKT_W), .DEPTH(Q_DEPTH)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .din       (q_in),
    .full      (q_full),
    .out_valid (pkt_valid),
    .out_ready (pkt_ready),
    .dout      (q_out)
  );

  assign {pkt_id, pkt_addr, pkt_data} = q_out;

  a_r10_stall_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (fire != '0)) |=> !trace_ready);
  a_r8_stall_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_ready && q_full && !pkt_ready) |=> !trace_ready);
  a_r10_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));
endmodule

// File: tb/test_trace_matcher.sv
module test_trace_matcher;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NM = 2;
  localparam int ID_W = 1;
  localparam int NF = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0, cfg_clear = 0;
  logic [ID_W-1:0] cfg_id = '0;
  logic [3:0] cfg_idx = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic trace_valid = 0, trace_ready;
  logic [W-1:0] tr_insn = '0, tr_src_pc = '0, tr_dst_pc = '0, tr_addr = '0, tr_data = '0;
  logic pkt_valid, pkt_ready = 1;
  logic [ID_W-1:0] pkt_id;
  logic [W-1:0] pkt_addr, pkt_data;

  int n_tests = 0, n_fail = 0;
  logic [ID_W+2*W-1:0] expq[$];
  logic [W-1:0] mval [NM][NF];
  logic [W-1:0] mmsk [NM][NF];
  int mthr [NM];
  int mcnt [NM];

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_matcher i_trace_matcher (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_clear(cfg_clear),
    .cfg_id(cfg_id), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .trace_valid(trace_valid), .trace_ready(trace_ready),
    .tr_insn(tr_insn), .tr_src_pc(tr_src_pc), .tr_dst_pc(tr_dst_pc),
    .tr_addr(tr_addr), .tr_data(tr_data),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_id(pkt_id), .pkt_addr(pkt_addr), .pkt_data(pkt_data));

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard: R4 R7 R9 R10
  always @(negedge clk) begin
    #1;
    if (rst_n && pkt_valid && pkt_ready) begin
      if (expq.size() == 0) begin
        check(0, "R9 unexpected packet", {pkt_id, pkt_addr, pkt_data}, 0);
      end else begin
        logic [ID_W+2*W-1:0] e;
        e = expq.pop_front();
        check({pkt_id, pkt_addr, pkt_data} == e, "R4 packet content/order",
              {pkt_id, pkt_addr, pkt_data}, e);
      end
    end
  end

  task automatic model_clear(input int m);
    for (int f = 0; f < NF; f++) begin mval[m][f] = '0; mmsk[m][f] = '0; end
    mthr[m] = 0; mcnt[m] = 0;
  endtask

  task automatic cfg_write(input int m, input int idx, input logic [W-1:0] d);
    @(negedge clk);
    cfg_valid = 1; cfg_clear = 0; cfg_id = ID_W'(m); cfg_idx = 4'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 0;
    if (idx == 15) mthr[m] = int'(d[15:0]);
    else if (idx < 5) mval[m][idx] = d;
    else if (idx >= 8 && idx < 13) mmsk[m][idx-8] = d;
  endtask

  task automatic cfg_clr(input int m);
    @(negedge clk);
    cfg_valid = 1; cfg_clear = 1; cfg_id = ID_W'(m);
    @(negedge clk);
    cfg_valid = 0; cfg_clear = 0;
    model_clear(m);
  endtask

  task automatic send(input logic [W-1:0] i, s, d, a, dt);
    logic [W-1:0] r [NF];
    @(negedge clk);
    trace_valid = 1; tr_insn = i; tr_src_pc = s; tr_dst_pc = d; tr_addr = a; tr_data = dt;
    while (!trace_ready) @(negedge clk);
    r[0] = i; r[1] = s; r[2] = d; r[3] = a; r[4] = dt;
    for (int m = 0; m < NM; m++) begin
      bit ok = (mthr[m] != 0);
      for (int f = 0; f < NF; f++)
        if (((r[f] ^ mval[m][f]) & ~mmsk[m][f]) != '0) ok = 0;
      if (ok) begin
        mcnt[m]++;
        if (mcnt[m] == mthr[m]) begin
          mcnt[m] = 0;
          expq.push_back({ID_W'(m), a, dt});
        end
      end
    end
    @(negedge clk);
    trace_valid = 0;
  endtask

  task automatic drain();
    int t = 0;
    while (expq.size() != 0 && t < 200) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R7 all expected packets delivered", expq.size(), 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<100000", wd);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    for (int m = 0; m < NM; m++) model_clear(m);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(trace_ready == 1, "R11 trace_ready after reset", trace_ready, 1);
    check(pkt_valid == 0, "R11 pkt_valid after reset", pkt_valid, 0);
    // R5 disabled matchers emit nothing
    send(32'h13, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    check(pkt_valid == 0, "R5 no packet while threshold 0", pkt_valid, 0);

    // R3 R12: matcher 0 exact insn 0x13, rest wildcard, threshold 3
    cfg_write(0, 0, 32'h13);
    for (int f = 1; f < NF; f++) cfg_write(0, 8 + f, '1);
    cfg_write(0, 15, 3);
    send(32'h13, 32'h100, 32'h104, 32'hA0, 32'h1);
    send(32'h13, 32'h104, 32'h108, 32'hA4, 32'h2);
    send(32'h33, 32'h108, 32'h10C, 32'hA8, 32'h3); // R2 mismatch, not counted
    // R4 latency: third hit; packet two cycles after handshake
    @(negedge clk);
    trace_valid = 1; tr_insn = 32'h13; tr_addr = 32'hAC; tr_data = 32'h4;
    @(negedge clk);
    trace_valid = 0;
    mcnt[0] = 0; expq.push_back({1'b0, 32'hAC, 32'h4});
    check(pkt_valid == 0, "R4 no packet one cycle after handshake", pkt_valid, 0);
    check(trace_ready == 0, "R10 stall the cycle after a firing record", trace_ready, 0);
    @(negedge clk);
    check(pkt_valid == 1, "R4 packet two cycles after handshake", pkt_valid, 1);
    check(pkt_addr == 32'hAC, "R4 packet address", pkt_addr, 32'hAC);
    send(32'h13, 0, 0, 32'hB0, 32'h5); // R3 counter restarted: count 1
    drain();

    // R1 R2: matcher 1 partial insn mask, exact address, threshold 1
    cfg_write(1, 0, 32'h63);
    cfg_write(1, 8, 32'hFFFF_FF00);
    cfg_write(1, 1, 32'h0); cfg_write(1, 9, '1);
    cfg_write(1, 2, 32'h0); cfg_write(1, 10, '1);
    cfg_write(1, 3, 32'h1000);
    cfg_write(1, 4, 32'h0); cfg_write(1, 12, '1);
    cfg_write(1, 15, 1);
    send(32'hABCD_0063, 32'h7, 32'h9, 32'h1000, 32'h55); // R1 hit
    send(32'h1234_5663, 32'h7, 32'h9, 32'h1000, 32'h56); // R1 hit
    send(32'hABCD_0073, 32'h7, 32'h9, 32'h1000, 32'h57); // R2 cared insn bit differs
    send(32'hABCD_0063, 32'h7, 32'h9, 32'h1004, 32'h58); // R2 address differs
    drain();

    // R6: clear matcher 0 only
    cfg_clr(0);
    send(32'h13, 0, 0, 32'hC0, 32'h9);
    send(32'h13, 0, 0, 32'hC4, 32'hA);
    send(32'h13, 0, 0, 32'hC8, 32'hB);
    send(32'hFF63, 0, 0, 32'h1000, 32'hC); // matcher 1 unaffected
    drain();

    // R10: one record fires both matchers
    for (int f = 0; f < NF; f++) cfg_write(0, 8 + f, '1);
    cfg_write(0, 15, 1);
    send(32'h0063, 0, 0, 32'h1000, 32'hD0);
    drain();

    // R8 R9 R7: fill queue with consumer stalled
    pkt_ready = 0;
    for (int k = 0; k < 9; k++) send(32'h1, 0, 0, 32'h2000 + k, 32'hE0 + k);
    @(negedge clk);
    check(trace_ready == 0, "R8 stall when queue full", trace_ready, 0);
    check(pkt_valid == 1, "R8 queue holds packets", pkt_valid, 1);
    held = pkt_data;
    @(negedge clk);
    check(pkt_data == held, "R7 packet stable while not taken", pkt_data, held);
    fork
      send(32'h1, 0, 0, 32'h2100, 32'hF0); // R9 held across stall, counted once
      begin
        repeat (6) @(negedge clk);
        check(trace_ready == 0, "R9 record still stalled", trace_ready, 0);
        pkt_ready = 1;
      end
    join
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule